// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss. A caller hands it a virtual page number, the base address of the top-level table, the page offset and the kind of access wanted. The walker reads one entry from each of two table levels, one read at a time, through a request/response memory port. It stops early when an entry is not marked valid. It narrows the permission set as it descends, and in the end it reports one of three outcomes: a finished translation, a page fault or a protection fault.

A finished translation delivers the physical page number, the combined permissions and the full physical address. Alongside it comes a fill strobe that a translation cache can use to store the last-level mapping, keyed by the whole virtual page number. A fault carries the faulting virtual page number and the level at which the walk stopped. Only one walk runs at a time, and a new one is taken only while the walker is idle.

Top module: `ptWalker`

## Requirements
- R1: After reset, walkReady is 1, memReqValid is 0, doneValid is 0 and fillValid is 0.
- R2: The first read goes to walkBase + upper index × 2^PTE_LOG2. The upper index is the top LVL_BITS bits of walkVpn.
- R3: The second read goes to (first-level PPN × 2^PAGE_LOG2) + lower index × 2^PTE_LOG2. The lower index is the bottom LVL_BITS bits of walkVpn.
- R4: memReqValid and memReqAddr hold steady until memReqReady is seen. No further request is raised until the response for the current one has arrived.
- R5: A walk is taken only when walkValid and walkReady are both 1. While a walk is running, walkReady is 0, and any walkValid or walkVpn change has no effect on the result.
- R6: If the first-level entry has bit 0 (valid) equal to 0, the walk ends with doneKind=1 (page fault) and doneLevel=0, and no second read is made.
- R7: If the second-level entry has its valid bit at 0, the walk ends with doneKind=1 and doneLevel=1.
- R8: An entry holds the valid bit in bit 0, the read, write and user permissions in bits 1, 2 and 3, and the PPN from bit 4 upward. On success, donePerm = {user, write, read} = the AND of the permission fields of both entries.
- R9: reqPerm is {user, write, read}. If it asks for a permission that the combined set lacks, a valid final entry ends the walk with doneKind=2 (protection fault) and doneLevel=1.
- R10: On success, doneKind=0, fillValid=1, donePpn is the second-level PPN, donePaddr = {donePpn, walkOffset}, and doneVpn equals the full walkVpn.
- R11: doneValid is high for exactly one cycle per walk. doneVpn carries the walk's VPN for faults too. On the next cycle walkReady is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| walkValid | input | 1 | New walk offered |
| walkReady | output | 1 | Walker is idle and will take a walk |
| walkVpn | input | 2*LVL_BITS | Virtual page number to translate |
| walkBase | input | PPN_W+PAGE_LOG2 | Top-level table base address |
| walkOffset | input | PAGE_LOG2 | Page offset carried into the physical address |
| reqPerm | input | 3 | Wanted access {user, write, read} |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory takes the request |
| memReqAddr | output | PPN_W+PAGE_LOG2 | Entry address |
| memRespValid | input | 1 | Entry data returned |
| memRespData | input | 8<<PTE_LOG2 | Entry contents |
| doneValid | output | 1 | One-cycle result strobe |
| doneKind | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| doneLevel | output | 1 | Level where the walk ended (0 first, 1 second) |
| doneVpn | output | 2*LVL_BITS | VPN of the finished walk |
| donePpn | output | PPN_W | Translated page number |
| donePerm | output | 3 | Combined permissions {user, write, read} |
| donePaddr | output | PPN_W+PAGE_LOG2 | Translated physical address |
| fillValid | output | 1 | Last-level mapping ready for the translation cache |

## Verification
A wrong walk state shows up at the memory port within one or two cycles of acceptance or of a response. The symptoms are a read at the wrong address, a second read after a first-level fault, or a request that drops before it is taken. A fault in the datapath registers stays hidden until doneValid, where it appears as a wrong PPN, wrong combined permissions, or a wrong kind or level. The bench therefore compares every request address and every result field against a table model built into the bench. It covers the whole VPN space, several access kinds, memory stalls and response delays, and walk requests held high while the walker is busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ1,
    ST_WAIT1,
    ST_REQ2,
    ST_WAIT2,
    ST_DONE
  } walkState_e;

  typedef struct packed {
    logic capWalk;   // latch a new walk
    logic capTop;    // latch first-level entry
    logic capLeaf;   // latch last-level entry
    logic levelSel;  // 0: first-level address, 1: second-level address
  } dpStrobe_t;

  localparam logic [1:0] KIND_OK   = 2'd0;
  localparam logic [1:0] KIND_PAGE = 2'd1;
  localparam logic [1:0] KIND_PROT = 2'd2;

  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_PERM_LSB  = 1;
  localparam int PERM_W        = 3;
  localparam int PTE_PPN_LSB   = 4;

endpackage

// File: rtl/ptwDatapath.sv
module ptwDatapath
  import ptw_pkg::*;
#(
  parameter int LVL_BITS  = 3,
  parameter int PTE_LOG2  = 3,
  parameter int PAGE_LOG2 = 12,
  parameter int PPN_W     = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobe_t                      strobe,
  input  logic [2*LVL_BITS-1:0]          walkVpn,
  input  logic [PPN_W+PAGE_LOG2-1:0]     walkBase,
  input  logic [PAGE_LOG2-1:0]           walkOffset,
  input  logic [PERM_W-1:0]              reqPerm,
  input  logic [(8<<PTE_LOG2)-1:0]       memRespData,
  output logic [PPN_W+PAGE_LOG2-1:0]     memReqAddr,
  output logic                           pteValid,
  output logic                           permOk,
  output logic [2*LVL_BITS-1:0]          vpnQ,
  output logic [PPN_W-1:0]               ppnQ,
  output logic [PERM_W-1:0]              permQ,
  output logic [PPN_W+PAGE_LOG2-1:0]     paddr
);

  localparam int VPN_W  = 2 * LVL_BITS;
  localparam int PA_W   = PPN_W + PAGE_LOG2;
  localparam int DATA_W = 8 << PTE_LOG2;

  logic [PA_W-1:0]      baseQ;
  logic [PA_W-1:0]      nextBaseQ;
  logic [PAGE_LOG2-1:0] offQ;
  logic [PERM_W-1:0]    reqQ;

  logic [PPN_W-1:0]  respPpn;
  logic [PERM_W-1:0] respPerm;
  logic [PERM_W-1:0] mergedPerm;
  logic [PA_W-1:0]   idxHi;
  logic [PA_W-1:0]   idxLo;

  assign respPpn    = memRespData[PTE_PPN_LSB +: PPN_W];
  assign respPerm   = memRespData[PTE_PERM_LSB +: PERM_W];
  assign pteValid   = memRespData[PTE_VALID_BIT];
  assign mergedPerm = permQ & respPerm;
  assign permOk     = ((reqQ & ~mergedPerm) == '0);

  assign idxHi = PA_W'(vpnQ[VPN_W-1 -: LVL_BITS]) << PTE_LOG2;
  assign idxLo = PA_W'(vpnQ[LVL_BITS-1:0]) << PTE_LOG2;

  always_comb begin
    if (strobe.levelSel) memReqAddr = nextBaseQ + idxLo;
    else                 memReqAddr = baseQ + idxHi;
  end

  assign paddr = {ppnQ, offQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ      <= '0;
      baseQ     <= '0;
      offQ      <= '0;
      reqQ      <= '0;
      nextBaseQ <= '0;
      ppnQ      <= '0;
      permQ     <= '0;
    end else begin
      if (strobe.capWalk) begin
        vpnQ  <= walkVpn;
        baseQ <= walkBase;
        offQ  <= walkOffset;
        reqQ  <= reqPerm;
        permQ <= '1;
      end
      if (strobe.capTop) begin
        nextBaseQ <= {respPpn, {PAGE_LOG2{1'b0}}};
        permQ     <= mergedPerm;
      end
      if (strobe.capLeaf) begin
        ppnQ  <= respPpn;
        permQ <= mergedPerm;
      end
    end
  end

  // Second-level reads stay inside the page named by the first-level entry.
  AST_L2_IN_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.levelSel |-> (memReqAddr[PA_W-1:PAGE_LOG2] == nextBaseQ[PA_W-1:PAGE_LOG2]))
    else $error("second-level address left its page"); // R3

  // Latching an entry never grants a permission that was not held before.
  AST_PERM_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capTop || strobe.capLeaf) |=> ((permQ & ~$past(permQ)) == '0))
    else $error("permission widened during walk"); // R8

endmodule

// File: rtl/ptwCtrl.sv
module ptwCtrl
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       walkValid,
  input  logic       memReqReady,
  input  logic       memRespValid,
  input  logic       pteValid,
  input  logic       permOk,
  input  logic [19:0] memReqAddrMon,
  output logic       walkReady,
  output logic       memReqValid,
  output dpStrobe_t  strobe,
  output logic       doneValid,
  output logic [1:0] doneKind,
  output logic       doneLevel
);

  walkState_e state, stateNext;
  logic [1:0] kindQ, kindNext;
  logic       levelQ, levelNext;

  assign walkReady   = (state == ST_IDLE);
  assign memReqValid = (state == ST_REQ1) || (state == ST_REQ2);
  assign doneValid   = (state == ST_DONE);
  assign doneKind    = kindQ;
  assign doneLevel   = levelQ;

  always_comb begin
    strobe          = '0;
    strobe.capWalk  = (state == ST_IDLE) && walkValid;
    strobe.levelSel = (state == ST_REQ2) || (state == ST_WAIT2);
    strobe.capTop   = (state == ST_WAIT1) && memRespValid && pteValid;
    strobe.capLeaf  = (state == ST_WAIT2) && memRespValid && pteValid;
  end

  always_comb begin
    stateNext = state;
    kindNext  = kindQ;
    levelNext = levelQ;
    unique case (state)
      ST_IDLE:  if (walkValid) stateNext = ST_REQ1;
      ST_REQ1:  if (memReqReady) stateNext = ST_WAIT1;
      ST_WAIT1: begin
        if (memRespValid) begin
          if (!pteValid) begin
            kindNext  = KIND_PAGE;
            levelNext = 1'b0;
            stateNext = ST_DONE;
          end else begin
            stateNext = ST_REQ2;
          end
        end
      end
      ST_REQ2:  if (memReqReady) stateNext = ST_WAIT2;
      ST_WAIT2: begin
        if (memRespValid) begin
          levelNext = 1'b1;
          stateNext = ST_DONE;
          if (!pteValid)    kindNext = KIND_PAGE;
          else if (!permOk) kindNext = KIND_PROT;
          else              kindNext = KIND_OK;
        end
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      kindQ  <= KIND_OK;
      levelQ <= 1'b0;
    end else begin
      state  <= stateNext;
      kindQ  <= kindNext;
      levelQ <= levelNext;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddrMon)))
    else $error("request dropped or moved before taken"); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    walkReady |-> (!memReqValid && !doneValid))
    else $error("idle walker is active"); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && walkReady))
    else $error("done strobe longer than one cycle"); // R11

  AST_L1_FAULT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WAIT1) && memRespValid && !pteValid) |=>
      (doneValid && !memReqValid && doneKind == KIND_PAGE))
    else $error("first-level fault did not end walk"); // R6

endmodule

// File: rtl/ptWalker.sv
module ptWalker
  import ptw_pkg::*;
#(
  parameter int LVL_BITS  = 3,
  parameter int PTE_LOG2  = 3,
  parameter int PAGE_LOG2 = 12,
  parameter int PPN_W     = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          walkValid,
  output logic                          walkReady,
  input  logic [2*LVL_BITS-1:0]         walkVpn,
  input  logic [PPN_W+PAGE_LOG2-1:0]    walkBase,
  input  logic [PAGE_LOG2-1:0]          walkOffset,
  input  logic [2:0]                    reqPerm,
  output logic                          memReqValid,
  input  logic                          memReqReady,
  output logic [PPN_W+PAGE_LOG2-1:0]    memReqAddr,
  input  logic                          memRespValid,
  input  logic [(8<<PTE_LOG2)-1:0]      memRespData,
  output logic                          doneValid,
  output logic [1:0]                    doneKind,
  output logic                          doneLevel,
  output logic [2*LVL_BITS-1:0]         doneVpn,
  output logic [PPN_W-1:0]              donePpn,
  output logic [2:0]                    donePerm,
  output logic [PPN_W+PAGE_LOG2-1:0]    donePaddr,
  output logic                          fillValid
);

  localparam int PA_W = PPN_W + PAGE_LOG2;

  dpStrobe_t strobe;
  logic      pteValid;
  logic      permOk;
  logic [19:0] addrMon;

  assign addrMon = 20'(memReqAddr);

  ptwCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .walkValid    (walkValid),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .pteValid     (pteValid),
    .permOk       (permOk),
    .memReqAddrMon(addrMon),
    .walkReady    (walkReady),
    .memReqValid  (memReqValid),
    .strobe       (strobe),
    .doneValid    (doneValid),
    .doneKind     (doneKind),
    .doneLevel    (doneLevel)
  );

  ptwDatapath #(
    .LVL_BITS (LVL_BITS),
    .PTE_LOG2 (PTE_LOG2),
    .PAGE_LOG2(PAGE_LOG2),
    .PPN_W    (PPN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .walkVpn    (walkVpn),
    .walkBase   (walkBase),
    .walkOffset (walkOffset),
    .reqPerm    (reqPerm),
    .memRespData(memRespData),
    .memReqAddr (memReqAddr),
    .pteValid   (pteValid),
    .permOk     (permOk),
    .vpnQ       (doneVpn),
    .ppnQ       (donePpn),
    .permQ      (donePerm),
    .paddr      (donePaddr)
  );

  assign fillValid = doneValid && (doneKind == KIND_OK);

  AST_FILL_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> (donePaddr[PA_W-1:PAGE_LOG2] == donePpn))
    else $error("fill address disagrees with PPN"); // R10

endmodule

// File: tb/ptWalker_tb.sv
module ptWalker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LVL_BITS  = 3;
  localparam int PTE_LOG2  = 3;
  localparam int PAGE_LOG2 = 12;
  localparam int PPN_W     = 8;
  localparam int VPN_W     = 2 * LVL_BITS;
  localparam int PA_W      = PPN_W + PAGE_LOG2;
  localparam int DATA_W    = 8 << PTE_LOG2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic walkValid = 1'b0;
  logic walkReady;
  logic [VPN_W-1:0] walkVpn = '0;
  logic [PA_W-1:0] walkBase = '0;
  logic [PAGE_LOG2-1:0] walkOffset = '0;
  logic [2:0] reqPerm = '0;
  logic memReqValid;
  logic memReqReady = 1'b0;
  logic [PA_W-1:0] memReqAddr;
  logic memRespValid = 1'b0;
  logic [DATA_W-1:0] memRespData = '0;
  logic doneValid;
  logic [1:0] doneKind;
  logic doneLevel;
  logic [VPN_W-1:0] doneVpn;
  logic [PPN_W-1:0] donePpn;
  logic [2:0] donePerm;
  logic [PA_W-1:0] donePaddr;
  logic fillValid;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptWalker #(.LVL_BITS(LVL_BITS), .PTE_LOG2(PTE_LOG2), .PAGE_LOG2(PAGE_LOG2), .PPN_W(PPN_W)) u_dut (
    .clk(clk), .rstN(rstN), .walkValid(walkValid), .walkReady(walkReady),
    .walkVpn(walkVpn), .walkBase(walkBase), .walkOffset(walkOffset), .reqPerm(reqPerm),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .doneValid(doneValid), .doneKind(doneKind), .doneLevel(doneLevel), .doneVpn(doneVpn),
    .donePpn(donePpn), .donePerm(donePerm), .donePaddr(donePaddr), .fillValid(fillValid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Table model: entry contents as a function of the entry address.
  function automatic logic [DATA_W-1:0] pteAt(input logic [PA_W-1:0] a);
    int unsigned h;
    logic [DATA_W-1:0] d;
    h = (int'(a) >> 3) * 37 + (int'(a) >> 12) * 101 + 13;
    d = '0;
    d[0] = ((h % 9) != 0);
    d[3:1] = (((h >> 4) % 3) == 0) ? 3'((h >> 7) & 7) : 3'b111;
    d[4 +: PPN_W] = PPN_W'((h * 7) >> 2);
    return d;
  endfunction

  task automatic serveRead(input logic [PA_W-1:0] expAddr, input string req,
                           input int stall, input int lat, input bit holdBusy);
    int w = 0;
    while (!memReqValid && w < 20) begin
      @(negedge clk);
      w++;
    end
    check(memReqValid, "R4", "request raised", longint'(memReqValid), 1);
    check(memReqAddr == expAddr, req, "entry address", longint'(memReqAddr), longint'(expAddr));
    if (holdBusy) check(!walkReady, "R5", "busy while walking", longint'(walkReady), 0);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(memReqValid && memReqAddr == expAddr, "R4", "request held",
            longint'(memReqAddr), longint'(expAddr));
    end
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    for (int l = 0; l < lat; l++) begin
      check(!memReqValid, "R4", "no request before response", longint'(memReqValid), 0);
      @(negedge clk);
    end
    check(!memReqValid, "R4", "no request before response", longint'(memReqValid), 0);
    memRespValid = 1'b1;
    memRespData  = pteAt(expAddr);
    @(negedge clk);
    memRespValid = 1'b0;
  endtask

  task automatic runWalk(input logic [VPN_W-1:0] vpn, input logic [PA_W-1:0] base,
                         input logic [PAGE_LOG2-1:0] off, input logic [2:0] req,
                         input int stall, input int lat, input bit holdBusy);
    logic [PA_W-1:0] a1, a2;
    logic [DATA_W-1:0] p1, p2;
    logic [1:0] eKind;
    logic eLevel;
    logic [2:0] ePerm;
    logic [PPN_W-1:0] ePpn;
    int w;
    a1 = base + (PA_W'(vpn[VPN_W-1 -: LVL_BITS]) << PTE_LOG2);
    p1 = pteAt(a1);
    a2 = {p1[4 +: PPN_W], {PAGE_LOG2{1'b0}}} + (PA_W'(vpn[LVL_BITS-1:0]) << PTE_LOG2);
    p2 = pteAt(a2);
    ePerm = p1[3:1] & p2[3:1];
    ePpn = p2[4 +: PPN_W];
    if (!p1[0]) begin eKind = 2'd1; eLevel = 1'b0; end
    else if (!p2[0]) begin eKind = 2'd1; eLevel = 1'b1; end
    else if ((req & ~ePerm) != 0) begin eKind = 2'd2; eLevel = 1'b1; end
    else begin eKind = 2'd0; eLevel = 1'b1; end

    check(walkReady, "R5", "ready before walk", longint'(walkReady), 1);
    walkValid = 1'b1; walkVpn = vpn; walkBase = base; walkOffset = off; reqPerm = req;
    @(negedge clk);
    if (holdBusy) walkVpn = vpn ^ 6'h21;
    else walkValid = 1'b0;

    serveRead(a1, "R2", stall, lat, holdBusy);
    if (p1[0]) serveRead(a2, "R3", lat, stall, holdBusy);

    w = 0;
    while (!doneValid && w < 20) begin
      check(!memReqValid, p1[0] ? "R7" : "R6", "no extra read", longint'(memReqValid), 0);
      @(negedge clk);
      w++;
    end
    walkValid = 1'b0;
    check(doneValid, "R11", "done raised", longint'(doneValid), 1);
    check(doneKind == eKind, eKind == 2 ? "R9" : (eKind == 1 ? (eLevel ? "R7" : "R6") : "R10"),
          "kind", longint'(doneKind), longint'(eKind));
    check(doneLevel == eLevel, "R6", "level", longint'(doneLevel), longint'(eLevel));
    check(doneVpn == vpn, holdBusy ? "R5" : "R11", "vpn", longint'(doneVpn), longint'(vpn));
    if (eKind == 2'd0) begin
      check(fillValid, "R10", "fill", longint'(fillValid), 1);
      check(donePpn == ePpn, "R10", "ppn", longint'(donePpn), longint'(ePpn));
      check(donePaddr == {ePpn, off}, "R10", "paddr", longint'(donePaddr), longint'({ePpn, off}));
      check(donePerm == ePerm, "R8", "perm", longint'(donePerm), longint'(ePerm));
    end else begin
      check(!fillValid, "R9", "no fill on fault", longint'(fillValid), 0);
    end
    @(negedge clk);
    check(!doneValid && walkReady, "R11", "pulse then idle",
          longint'({doneValid, walkReady}), 1);
    check(!memReqValid, "R5", "held request not taken", longint'(memReqValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(walkReady == 1'b1, "R1", "reset ready", longint'(walkReady), 1);
    check(!memReqValid, "R1", "reset request", longint'(memReqValid), 0);
    check(!doneValid && !fillValid, "R1", "reset done", longint'({doneValid, fillValid}), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int b = 0; b < 2; b++) begin
      for (int v = 0; v < (1 << VPN_W); v++) begin
        for (int r = 0; r < 4; r++) begin
          logic [2:0] rq;
          rq = (r == 0) ? 3'b001 : (r == 1) ? 3'b011 : (r == 2) ? 3'b101 : 3'b111;
          runWalk(VPN_W'(v), (b == 0) ? PA_W'(20'h0_3000) : PA_W'(20'h4_5a8),
                  PAGE_LOG2'(v * 61 + r), rq, v % 3, (v >> 1) % 3, (r == 3));
        end
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule